// File: doc/BRIEF.md
# Newest-First Overwriting Ring Buffer

This block holds a bounded history of data items and hands them back newest first. Each read request removes and returns the most recently written item still retained, so a consumer that asks occasionally always gets the freshest data rather than something that has waited in a queue. The producer is never stalled: once the store is full, each new write drops the oldest retained item to make room.

Beside the consuming read path sits a separate latest-value register. It follows every write and can be sampled at any time without changing what is stored. This makes it suitable for health monitoring. A sampler that polls it may see one value twice or miss values, and the stored data is not affected either way. An occupancy count and two sticky status flags (overflow and underflow) complete the interface.

Top module: `newest_first_ring`

## Requirements
- R1: A read request with one or more items stored and no write in the same cycle returns the newest retained item on `rd_data`, with `rd_valid` high in the following cycle, and removes it (count drops by one).
- R2: A write while count equals DEPTH discards the oldest retained item, stores the new one, and leaves count at DEPTH. No input is ever refused.
- R3: Successive reads return the retained items in exact reverse order of writing.
- R4: `count` equals the number of retained items, always in the range 0 to DEPTH.
- R5: A read request with count zero and no write in the same cycle gives `rd_valid` low in the next cycle and sets the underflow flag.
- R6: A write and a read in the same cycle return the written data on the read port in the next cycle. Count and stored contents are unchanged.
- R7: `latest_data` takes the data of every write, including a write in the same cycle as a read. Reads leave it unchanged. `latest_valid` goes high after the first write.
- R8: The overflow flag (set by R2) and the underflow flag (set by R5) stay high until `clr_flags` is high at a clock edge. A set event in the same cycle as a clear leaves the flag high.
- R9: After reset, count is 0, both flags are low, and `rd_valid`, `latest_valid` and `latest_data` are all 0.
- R10: `rd_valid` is low in any cycle that follows a cycle without a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| rd_req | input | 1 | Consuming read request |
| rd_data | output | DATA_W | Read data, meaningful while rd_valid is high |
| rd_valid | output | 1 | Read result valid, one cycle after rd_req |
| count | output | $clog2(DEPTH+1) | Number of retained items |
| latest_data | output | DATA_W | Data of the most recent write |
| latest_valid | output | 1 | At least one write since reset |
| overflow_flag | output | 1 | Sticky: a write discarded an old item |
| underflow_flag | output | 1 | Sticky: a read found the store empty |
| clr_flags | input | 1 | Clears both sticky flags |

## Verification
The bench fills the store past its depth and then drains it completely. A design that overwrote the newest entry instead of the oldest, or that let the count run past DEPTH, would return the wrong sequence or a wrong occupancy. Same-cycle reads and writes are applied on an empty store, a partly filled store and a full store. A design that stored the bypassed item, or that flagged underflow when it should have passed the data through, would show a count drift or a false flag. Reads on an empty store, and flag clears that land in the same cycle as a set, expose a flag that is not sticky or a clear that wins when it should lose. A long mixed run checks every cycle against a queue model. Wrap-around faults in the head pointer show up there as out-of-order data.

// File: rtl/nfr_pkg.sv
package nfr_pkg;

   typedef enum logic [2:0] {
      NFR_IDLE,
      NFR_PUSH,
      NFR_PUSH_FULL,
      NFR_POP,
      NFR_POP_EMPTY,
      NFR_PASS
   } nfr_op_e;

   function automatic nfr_op_e nfr_decode(input logic wr, input logic rd,
                                          input logic empty, input logic full);
      nfr_op_e op;
      if (wr && rd)      op = NFR_PASS;
      else if (wr)       op = full  ? NFR_PUSH_FULL : NFR_PUSH;
      else if (rd)       op = empty ? NFR_POP_EMPTY : NFR_POP;
      else               op = NFR_IDLE;
      return op;
   endfunction

endpackage

// File: rtl/nfr_ctrl.sv
module nfr_ctrl #(
   parameter int DEPTH = 2048,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic          rd,
   output logic          mem_we,
   output logic [AW-1:0] mem_waddr,
   output logic [AW-1:0] mem_raddr,
   output logic          pop,
   output logic          pass,
   output logic          ovf_set,
   output logic          und_set,
   output logic [CW-1:0] count
);
   import nfr_pkg::*;

   localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

   logic [AW-1:0] head, head_inc, head_dec;
   nfr_op_e       op;

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign head_inc = head + AW'(1);
         assign head_dec = head - AW'(1);
      end else begin : g_mod
         assign head_inc = (head == AW'(DEPTH - 1)) ? '0 : head + AW'(1);
         assign head_dec = (head == '0) ? AW'(DEPTH - 1) : head - AW'(1);
      end
   endgenerate

   always_comb op = nfr_decode(wr, rd, count == '0, count == FULL_C);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head  <= '0;
         count <= '0;
      end else begin
         unique case (op)
            NFR_PUSH: begin
               head  <= head_inc;
               count <= count + CW'(1);
            end
            NFR_PUSH_FULL: head <= head_inc;
            NFR_POP: begin
               head  <= head_dec;
               count <= count - CW'(1);
            end
            default: ;
         endcase
      end
   end

   assign mem_we    = (op == NFR_PUSH) || (op == NFR_PUSH_FULL);
   assign mem_waddr = head;
   assign mem_raddr = head_dec;
   assign pop       = (op == NFR_POP);
   assign pass      = (op == NFR_PASS);
   assign ovf_set   = (op == NFR_PUSH_FULL);
   assign und_set   = (op == NFR_POP_EMPTY);
endmodule

// File: rtl/nfr_store.sv
module nfr_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 2048,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   input  logic              pop,
   input  logic              pass,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
         rdata  <= '0;
      end else begin
         rvalid <= pop | pass;
         if (pass)     rdata <= wdata;
         else if (pop) rdata <= mem[raddr];
      end
   end
endmodule

// File: rtl/nfr_status.sv
module nfr_status #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ovf_set,
   input  logic              und_set,
   input  logic              clr,
   output logic [DATA_W-1:0] latest,
   output logic              latest_ok,
   output logic              ovf,
   output logic              und
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         latest    <= '0;
         latest_ok <= 1'b0;
         ovf       <= 1'b0;
         und       <= 1'b0;
      end else begin
         if (wr) begin
            latest    <= wdata;
            latest_ok <= 1'b1;
         end
         ovf <= (ovf & ~clr) | ovf_set;
         und <= (und & ~clr) | und_set;
      end
   end
endmodule

// File: rtl/newest_first_ring.sv
module newest_first_ring #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 2048,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_req,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic [CW-1:0]     count,
   output logic [DATA_W-1:0] latest_data,
   output logic              latest_valid,
   output logic              overflow_flag,
   output logic              underflow_flag,
   input  logic              clr_flags
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("newest_first_ring: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("newest_first_ring: DATA_W must be at least 1");
      end
   endgenerate

   logic          mem_we, pop, pass, ovf_set, und_set;
   logic [AW-1:0] waddr, raddr;

   nfr_ctrl #(.DEPTH(DEPTH)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .wr(wr_valid), .rd(rd_req),
      .mem_we(mem_we), .mem_waddr(waddr), .mem_raddr(raddr),
      .pop(pop), .pass(pass), .ovf_set(ovf_set), .und_set(und_set),
      .count(count)
   );

   nfr_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
      .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(waddr), .wdata(wr_data),
      .raddr(raddr), .pop(pop), .pass(pass), .rdata(rd_data), .rvalid(rd_valid)
   );

   nfr_status #(.DATA_W(DATA_W)) status_i (
      .clk(clk), .rst_n(rst_n), .wr(wr_valid), .wdata(wr_data),
      .ovf_set(ovf_set), .und_set(und_set), .clr(clr_flags),
      .latest(latest_data), .latest_ok(latest_valid),
      .ovf(overflow_flag), .und(underflow_flag)
   );
endmodule

// File: rtl/nfr_checker.sv
module nfr_checker #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 2048,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic [DATA_W-1:0] wr_data,
   input logic              rd_req,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_valid,
   input logic [CW-1:0]     count,
   input logic [DATA_W-1:0] latest_data,
   input logic              overflow_flag,
   input logic              underflow_flag,
   input logic              clr_flags
);
   a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   a_r1_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !wr_valid && count != '0) |=> (rd_valid && count == $past(count) - CW'(1)));

   a_r2_full_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !rd_req && count == CW'(DEPTH)) |=> (count == CW'(DEPTH) && overflow_flag));

   a_r5_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !wr_valid && count == '0) |=> (!rd_valid && underflow_flag));

   a_r6_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && rd_req) |=> (rd_valid && rd_data == $past(wr_data) && $stable(count)));

   a_r7_latest: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> (latest_data == $past(wr_data)));

   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow_flag && !clr_flags) |=> overflow_flag);

   a_r8_und_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (underflow_flag && !clr_flags) |=> underflow_flag);

   a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rd_valid);
endmodule

bind newest_first_ring nfr_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
   .rd_req(rd_req), .rd_data(rd_data), .rd_valid(rd_valid), .count(count),
   .latest_data(latest_data), .overflow_flag(overflow_flag),
   .underflow_flag(underflow_flag), .clr_flags(clr_flags)
);

// File: tb/newest_first_ring_tb_top.sv
module newest_first_ring_tb_top;
   localparam int DW = 16;
   localparam int DP = 4;
   localparam int CW = $clog2(DP + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0, rd_req = 1'b0, clr_flags = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data, latest_data;
   logic          rd_valid, latest_valid, overflow_flag, underflow_flag;
   logic [CW-1:0] count;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   newest_first_ring #(.DATA_W(DW), .DEPTH(DP)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
      .rd_req(rd_req), .rd_data(rd_data), .rd_valid(rd_valid), .count(count),
      .latest_data(latest_data), .latest_valid(latest_valid),
      .overflow_flag(overflow_flag), .underflow_flag(underflow_flag),
      .clr_flags(clr_flags)
   );

   // behavioural model: back of queue is newest
   logic [DW-1:0] q[$];
   logic [DW-1:0] m_rd, m_latest;
   logic          m_rv, m_lv, m_ovf, m_und;

   task automatic chk(input string req, input string what, input longint got, input longint exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
      end
   endtask

   task automatic compare_all(input string req);
      chk(req, "count", count, q.size());
      chk(req, "rd_valid", rd_valid, m_rv);
      if (m_rv) chk(req, "rd_data", rd_data, m_rd);
      chk(req, "latest_data", latest_data, m_latest);
      chk(req, "latest_valid", latest_valid, m_lv);
      chk(req, "overflow_flag", overflow_flag, m_ovf);
      chk(req, "underflow_flag", underflow_flag, m_und);
   endtask

   task automatic step(input logic w, input logic [DW-1:0] d, input logic r,
                       input logic c, input string req_in);
      string req;
      logic  so, su;
      req = req_in;
      wr_valid = w; wr_data = d; rd_req = r; clr_flags = c;
      @(posedge clk);
      so = 1'b0; su = 1'b0; m_rv = 1'b0;
      if (w && r) begin
         m_rv = 1'b1; m_rd = d;
         if (req == "") req = "R6";
      end else if (r) begin
         if (q.size() > 0) begin
            m_rv = 1'b1; m_rd = q.pop_back();
            if (req == "") req = "R1";
         end else begin
            su = 1'b1;
            if (req == "") req = "R5";
         end
      end else if (w) begin
         if (q.size() == DP) begin
            void'(q.pop_front()); so = 1'b1;
            if (req == "") req = "R2";
         end
         q.push_back(d);
      end else if (req == "") req = "R10";
      if (w) begin m_latest = d; m_lv = 1'b1; end
      m_ovf = (m_ovf & ~c) | so;
      m_und = (m_und & ~c) | su;
      @(negedge clk);
      wr_valid = 1'b0; rd_req = 1'b0; clr_flags = 1'b0;
      compare_all(req);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      m_rd = '0; m_latest = '0; m_rv = 0; m_lv = 0; m_ovf = 0; m_und = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      compare_all("R9");                         // reset state
      chk("R9", "rd_data_reset", rd_data, 0);

      // R3: LIFO order
      step(1, 16'h0011, 0, 0, "R4");
      step(1, 16'h0022, 0, 0, "R4");
      step(1, 16'h0033, 0, 0, "R4");
      step(0, 0, 1, 0, "R3");
      step(0, 0, 1, 0, "R3");
      step(1, 16'h0044, 0, 0, "R4");
      step(0, 0, 1, 0, "R3");
      step(0, 0, 1, 0, "R3");
      step(0, 0, 0, 0, "R10");
      // R5: empty read sets sticky underflow
      step(0, 0, 1, 0, "R5");
      step(0, 0, 0, 0, "R8");
      step(0, 0, 0, 1, "R8");
      // R6 on empty store: bypass, no underflow, count stays 0
      step(1, 16'h0abc, 1, 0, "R6");
      // R2: fill past depth
      for (int i = 1; i <= DP + 2; i++) step(1, DW'(16'h0100 + i), 0, 0, "R2");
      step(1, 16'h0bbb, 1, 0, "R6");             // bypass on full
      step(0, 0, 0, 0, "R7");                    // latest holds across idle
      step(0, 0, 1, 0, "R7");                    // read leaves latest alone
      step(1, 16'h0ccc, 1, 0, "R6");             // bypass on partial
      for (int i = 0; i < DP; i++) step(0, 0, 1, 0, "R3");
      // R8: set and clear in same cycle: set wins
      step(1, 16'h0d01, 0, 1, "R8");
      step(0, 0, 1, 1, "R8");
      step(0, 0, 1, 1, "R8");
      step(0, 0, 0, 1, "R8");
      // mixed traffic against the model
      for (int i = 0; i < 3000; i++) begin
         logic w, r, c;
         w = ($urandom % 100) < 55;
         r = ($urandom % 100) < 45;
         c = ($urandom % 100) < 4;
         step(w, DW'($urandom), r, c, "");
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule